// File: doc/BRIEF.md
# Half-Duplex CSMA/CD Transmit Arbiter

This block decides when a MAC may put a frame on the wire. A frame builder holds `tx_req` high while it has a frame pending. The arbiter grants the medium by raising `tx_en`, and it learns that the frame has ended through a one-cycle `frame_end` strobe. In half-duplex mode it waits while carrier is present and then keeps an inter-frame gap. If a collision occurs, it sends a jam sequence and waits a truncated binary exponential back-off before retrying. After a fixed number of collisions it gives up. When the receive side is short of buffers, it jams on foreign carrier to push back on other stations. In full-duplex mode, carrier and collision are ignored. Flow control then becomes a request to an external frame builder for a PAUSE frame: one request carries a slot count when the buffers run low, and a second request carries zero when they recover.

All timing is counted in bit times from a bit-tick divider. The divider runs at one of two rates chosen by `speed_100` and restarts on every state change, so every interval starts on a clean bit boundary. The controller has five named states:
- ST_IDLE leads to ST_DEFER on a request.
- ST_DEFER leads to ST_XMIT once the gap has elapsed on an idle medium.
- ST_XMIT leads to ST_IDLE on frame end (done), or to ST_JAM on a half-duplex collision.
- ST_JAM leads to ST_IDLE when the limit is reached or retry is disabled (abort). With a back-off of zero it leads to ST_DEFER, and otherwise to ST_BACKOFF.
- ST_BACKOFF leads to ST_DEFER after the drawn number of slots.

Top module: `csma_tx_arbiter`

## Requirements
- R1: In half-duplex mode, ST_XMIT is never entered while `carrier_sense` is high; any carrier seen in ST_DEFER restarts the gap count.
- R2: `tx_en` rises exactly IFG_BITS bit times after the medium is seen idle in ST_DEFER; from a request in ST_IDLE, it rises 1 + IFG_BITS×divider cycles after the request.
- R3: A half-duplex collision while transmitting raises `jam` and `tx_en` together on the next cycle, and holds them for exactly JAM_BITS bit times.
- R4: After the n-th collision the arbiter waits k×SLOT_BITS bit times, with k drawn from an LFSR in 0 .. 2^min(n,BACKOFF_CAP)−1, and then waits IFG_BITS more before retransmitting.
- R5: Once a frame has collided ATTEMPT_LIMIT times (16 by default), the arbiter pulses `tx_abort` for one cycle and sets `coll_count` to ATTEMPT_LIMIT.
- R6: With `retry_dis` high, the first collision ends in `tx_abort` with `coll_count` = 1.
- R7: `frame_end` while transmitting gives a one-cycle `tx_done`, and `coll_count` then holds the number of collisions that frame suffered; `tx_done` and `tx_abort` never occur together.
- R8: In half-duplex mode, when the arbiter is not sending its own frame, `rx_buf_low` together with `carrier_sense` drives `jam` and `tx_en` high; without either of them `jam` stays low.
- R9: In full-duplex mode, `carrier_sense` and `collision` have no effect: a request is granted after the gap, and `jam` stays low.
- R10: In full-duplex mode, a rising `rx_buf_low` gives a one-cycle `pause_req` with `pause_slots` = PAUSE_SLOTS, and a falling `rx_buf_low` gives one with `pause_slots` = 0; in half-duplex mode `pause_req` stays low.
- R11: `speed_100` = 1 makes one bit time FAST_DIV clock cycles; `speed_100` = 0 makes it SLOW_DIV cycles.
- R12: After reset, `tx_en`, `jam`, `tx_done`, `tx_abort`, `pause_req` and `coll_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| full_duplex | input | 1 | 1 selects full-duplex, 0 selects half-duplex CSMA/CD |
| speed_100 | input | 1 | 1 selects the fast bit time, 0 the slow one |
| retry_dis | input | 1 | Abort on the first collision instead of retrying |
| tx_req | input | 1 | A frame is pending |
| frame_end | input | 1 | One-cycle strobe: the last bit of the frame has been sent |
| carrier_sense | input | 1 | Medium is busy |
| collision | input | 1 | Collision detected on the medium |
| rx_buf_low | input | 1 | Receive buffers are short |
| tx_en | output | 1 | Transmitter drives the medium (frame or jam) |
| jam | output | 1 | The transmitted data must be the jam pattern |
| tx_done | output | 1 | One-cycle pulse: frame sent |
| tx_abort | output | 1 | One-cycle pulse: frame dropped |
| coll_count | output | 5 | Collisions suffered by the last finished frame |
| pause_req | output | 1 | One-cycle request for a PAUSE frame |
| pause_slots | output | 16 | Slot count carried by the requested PAUSE frame |

## Verification
The grant path is tried with carrier held busy and then dropped, which separates a gap counted from idle carrier from a gap counted from the request. It is also tried from an idle medium at both speeds, which separates the two bit-time rates. Collision patterns include a single collision, a collision on every attempt, and a collision with retry disabled. The gaps these produce separate correct back-off windows, the retry limit and the no-retry abort. Carrier and collision held high in full-duplex mode, and toggling of the buffer-low input in both modes, tell back-pressure jamming apart from PAUSE requests.

// File: rtl/csma_pkg.sv
package csma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEFER,
        ST_XMIT,
        ST_JAM,
        ST_BACKOFF
    } arb_state_t;
endpackage

// File: rtl/csma_bit_clock.sv
module csma_bit_clock #(
    parameter int FAST_DIV = 1,
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_100,
    input  logic restart,
    output logic bit_tick
);
    localparam int W = (SLOW_DIV > FAST_DIV) ? $clog2(SLOW_DIV + 1) : $clog2(FAST_DIV + 1);
    localparam logic [W-1:0] LIM_FAST = W'(FAST_DIV - 1);
    localparam logic [W-1:0] LIM_SLOW = W'(SLOW_DIV - 1);

    logic [W-1:0] div_cnt;
    logic [W-1:0] lim;

    assign lim      = speed_100 ? LIM_FAST : LIM_SLOW;
    assign bit_tick = (div_cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  div_cnt <= '0;
        else if (restart || bit_tick) div_cnt <= '0;
        else                         div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/csma_backoff_rng.sv
module csma_backoff_rng #(
    parameter int                 LFSR_W = 16,
    parameter int                 CAP    = 10,
    parameter int                 CW     = 5,
    parameter logic [LFSR_W-1:0]  TAPS   = 16'hB400,
    parameter logic [LFSR_W-1:0]  SEED   = 16'h5A5B
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] coll_n,
    output logic [CAP-1:0] slots
);
    logic [LFSR_W-1:0] lfsr;
    logic [CW-1:0]     expo;
    logic [CAP-1:0]    mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr <= SEED;
        else        lfsr <= {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? TAPS : '0);
    end

    assign expo = (coll_n > CW'(CAP)) ? CW'(CAP) : coll_n;

    always_comb begin
        for (int i = 0; i < CAP; i++) mask[i] = (CW'(i) < expo);
    end

    assign slots = lfsr[CAP-1:0] & mask;
endmodule

// File: rtl/csma_tx_arbiter.sv
module csma_tx_arbiter
    import csma_pkg::*;
#(
    parameter int          SLOT_BITS     = 512,
    parameter int          IFG_BITS      = 96,
    parameter int          JAM_BITS      = 32,
    parameter int          ATTEMPT_LIMIT = 16,
    parameter int          BACKOFF_CAP   = 10,
    parameter int          FAST_DIV      = 1,
    parameter int          SLOW_DIV      = 10,
    parameter logic [15:0] PAUSE_SLOTS   = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        full_duplex,
    input  logic        speed_100,
    input  logic        retry_dis,
    input  logic        tx_req,
    input  logic        frame_end,
    input  logic        carrier_sense,
    input  logic        collision,
    input  logic        rx_buf_low,
    output logic        tx_en,
    output logic        jam,
    output logic        tx_done,
    output logic        tx_abort,
    output logic [4:0]  coll_count,
    output logic        pause_req,
    output logic [15:0] pause_slots
);
    localparam int CW     = 5;
    localparam int MAXB   = (SLOT_BITS > IFG_BITS) ?
                            ((SLOT_BITS > JAM_BITS) ? SLOT_BITS : JAM_BITS) :
                            ((IFG_BITS > JAM_BITS) ? IFG_BITS : JAM_BITS);
    localparam int BW     = $clog2(MAXB + 1);
    localparam logic [BW-1:0] IFG_END  = BW'(IFG_BITS - 1);
    localparam logic [BW-1:0] JAM_END  = BW'(JAM_BITS - 1);
    localparam logic [BW-1:0] SLOT_END = BW'(SLOT_BITS - 1);
    localparam logic [CW-1:0] LIMIT    = CW'(ATTEMPT_LIMIT);

    arb_state_t             state, state_n;
    logic [BW-1:0]          bit_cnt;
    logic [BACKOFF_CAP-1:0] slot_left;
    logic [BACKOFF_CAP-1:0] backoff_k;
    logic [CW-1:0]          coll_cnt;
    logic                   bit_tick;
    logic                   restart;
    logic                   medium_busy;
    logic                   backpressure;
    logic                   rxlow_q;

    assign medium_busy = !full_duplex && carrier_sense;
    assign restart     = (state_n != state) || (state == ST_DEFER && medium_busy);

    csma_bit_clock #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_bitclk (
        .clk(clk), .rst_n(rst_n), .speed_100(speed_100),
        .restart(restart), .bit_tick(bit_tick)
    );

    csma_backoff_rng #(.CAP(BACKOFF_CAP), .CW(CW)) u_rng (
        .clk(clk), .rst_n(rst_n), .coll_n(coll_cnt), .slots(backoff_k)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (tx_req) state_n = ST_DEFER;
            ST_DEFER:   if (!medium_busy && bit_tick && bit_cnt == IFG_END) state_n = ST_XMIT;
            ST_XMIT: begin
                if (!full_duplex && collision) state_n = ST_JAM;
                else if (frame_end)            state_n = ST_IDLE;
            end
            ST_JAM: begin
                if (bit_tick && bit_cnt == JAM_END) begin
                    if (retry_dis || coll_cnt >= LIMIT) state_n = ST_IDLE;
                    else if (backoff_k == '0)           state_n = ST_DEFER;
                    else                                state_n = ST_BACKOFF;
                end
            end
            ST_BACKOFF: if (bit_tick && bit_cnt == SLOT_END &&
                            slot_left == BACKOFF_CAP'(1)) state_n = ST_DEFER;
            default:    state_n = ST_IDLE;
        endcase
    end

    // counters and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            slot_left   <= '0;
            coll_cnt    <= '0;
            coll_count  <= '0;
            tx_done     <= 1'b0;
            tx_abort    <= 1'b0;
            rxlow_q     <= 1'b0;
            pause_req   <= 1'b0;
            pause_slots <= '0;
        end else begin
            tx_done   <= (state == ST_XMIT) && (state_n == ST_IDLE);
            tx_abort  <= (state == ST_JAM)  && (state_n == ST_IDLE);
            if (state_n != state) begin
                bit_cnt <= '0;
            end else if (state == ST_DEFER && medium_busy) begin
                bit_cnt <= '0;
            end else if (bit_tick) begin
                if (state == ST_BACKOFF && bit_cnt == SLOT_END) begin
                    bit_cnt   <= '0;
                    slot_left <= slot_left - 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
            if (state == ST_JAM && state_n == ST_BACKOFF) slot_left <= backoff_k;
            if (state == ST_IDLE && state_n == ST_DEFER)  coll_cnt  <= '0;
            if (state == ST_XMIT && state_n == ST_JAM)    coll_cnt  <= coll_cnt + 1'b1;
            if ((state == ST_XMIT || state == ST_JAM) && state_n == ST_IDLE)
                coll_count <= coll_cnt;
            rxlow_q   <= rx_buf_low;
            pause_req <= full_duplex && (rx_buf_low != rxlow_q);
            if (full_duplex && rx_buf_low != rxlow_q)
                pause_slots <= rx_buf_low ? PAUSE_SLOTS : 16'h0000;
        end
    end

    assign backpressure = !full_duplex && rx_buf_low && carrier_sense &&
                          (state == ST_IDLE || state == ST_DEFER || state == ST_BACKOFF);
    assign jam   = (state == ST_JAM) || backpressure;
    assign tx_en = (state == ST_XMIT) || jam;

    AST_DEFER_ON_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEFER && !full_duplex && carrier_sense) |=> state != ST_XMIT); // R1
    AST_COLLISION_JAMS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XMIT && !full_duplex && collision) |=> (jam && tx_en)); // R3
    AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> (coll_count == LIMIT || $past(retry_dis))); // R5
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        coll_count <= LIMIT); // R5
    AST_DONE_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && tx_abort)); // R7
    AST_FD_NO_JAM: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex && $past(full_duplex) && state != ST_JAM) |-> !jam); // R9
    AST_PAUSE_FD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req |-> $past(full_duplex)); // R10
endmodule

// File: tb/tb_csma_tx_arbiter.sv
module tb_csma_tx_arbiter;
    localparam int SLOT = 8;
    localparam int IFG  = 4;
    localparam int JAMB = 4;
    localparam int LIM  = 16;
    localparam int CAP  = 4;
    localparam int SDIV = 4;
    localparam logic [15:0] PSL = 16'h0123;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic full_duplex = 1'b0, speed_100 = 1'b1, retry_dis = 1'b0, tx_req = 1'b0;
    logic frame_end = 1'b0, carrier_sense = 1'b0, collision = 1'b0, rx_buf_low = 1'b0;
    logic tx_en, jam, tx_done, tx_abort, pause_req;
    logic [4:0]  coll_count;
    logic [15:0] pause_slots;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    csma_tx_arbiter #(
        .SLOT_BITS(SLOT), .IFG_BITS(IFG), .JAM_BITS(JAMB), .ATTEMPT_LIMIT(LIM),
        .BACKOFF_CAP(CAP), .FAST_DIV(1), .SLOW_DIV(SDIV), .PAUSE_SLOTS(PSL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .speed_100(speed_100),
        .retry_dis(retry_dis), .tx_req(tx_req), .frame_end(frame_end),
        .carrier_sense(carrier_sense), .collision(collision), .rx_buf_low(rx_buf_low),
        .tx_en(tx_en), .jam(jam), .tx_done(tx_done), .tx_abort(tx_abort),
        .coll_count(coll_count), .pause_req(pause_req), .pause_slots(pause_slots)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_grant(output int n);
        n = 0;
        while (!tx_en && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_frame(input int exp_coll, input string req);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        tx_req    = 1'b0;
        chk(tx_done == 1'b1, req, "tx_done pulse", tx_done, 1);
        chk(coll_count == 5'(exp_coll), req, "coll_count at done", coll_count, exp_coll);
        @(negedge clk);
        chk(tx_done == 1'b0 && tx_en == 1'b0, req, "done one cycle, tx_en off", tx_done, 0);
    endtask

    task automatic jam_len(output int j);
        j = 0;
        while (jam && j < 5000) begin
            j++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk(tx_en == 0 && jam == 0 && tx_done == 0 && tx_abort == 0 && pause_req == 0,
            "R12", "outputs idle after reset", {tx_en, jam, tx_done, tx_abort, pause_req}, 0);
        chk(coll_count == 0, "R12", "coll_count after reset", coll_count, 0);
    endtask

    task automatic t_defer;
        int n;
        bit seen = 1'b0;
        carrier_sense = 1'b1;
        tx_req = 1'b1;
        repeat (30) begin
            @(negedge clk);
            if (tx_en) seen = 1'b1;
        end
        chk(!seen, "R1", "no grant while carrier busy", seen, 0);
        carrier_sense = 1'b0;
        wait_grant(n);
        chk(n == IFG, "R2", "gap after carrier drop", n, IFG);
        finish_frame(0, "R7");
    endtask

    task automatic t_collision;
        int n, j, g;
        tx_req = 1'b1;
        wait_grant(n);
        chk(n == 1 + IFG, "R2", "grant from request", n, 1 + IFG);
        collision = 1'b1;
        @(negedge clk);
        collision = 1'b0;
        chk(jam && tx_en, "R3", "jam after collision", jam, 1);
        jam_len(j);
        chk(j == JAMB, "R3", "jam length", j, JAMB);
        wait_grant(g);
        chk(g == IFG || g == IFG + SLOT, "R4", "first back-off gap", g, IFG);
        finish_frame(1, "R7");
    endtask

    task automatic t_abort;
        int j, g, n, k;
        bit aborted = 1'b0;
        bit done_seen = 1'b0;
        n = 0;
        collision = 1'b1;
        tx_req = 1'b1;
        while (!aborted && n < 40) begin
            k = 0;
            while (!jam && k < 5000) begin
                @(negedge clk);
                k++;
            end
            n++;
            jam_len(j);
            chk(j == JAMB, "R3", "jam length per attempt", j, JAMB);
            if (tx_done) done_seen = 1'b1;
            if (tx_abort) begin
                aborted = 1'b1;
                tx_req = 1'b0;
                collision = 1'b0;
                chk(n == LIM, "R5", "collisions before abort", n, LIM);
                chk(coll_count == 5'(LIM), "R5", "coll_count at abort", coll_count, LIM);
            end else begin
                chk(n < LIM, "R5", "no abort before limit", n, LIM);
                wait_grant(g);
                k = (n < CAP) ? (1 << n) : (1 << CAP);
                chk(g >= IFG && (g - IFG) % SLOT == 0 && (g - IFG) / SLOT < k,
                    "R4", "back-off window", g, IFG);
            end
        end
        chk(aborted, "R5", "abort reached", aborted, 1);
        chk(!done_seen, "R7", "no done on aborted frame", done_seen, 0);
        @(negedge clk);
        chk(tx_abort == 1'b0, "R5", "abort one cycle", tx_abort, 0);
    endtask

    task automatic t_retry_dis;
        int k, j;
        retry_dis = 1'b1;
        collision = 1'b1;
        tx_req = 1'b1;
        k = 0;
        while (!jam && k < 5000) begin
            @(negedge clk);
            k++;
        end
        jam_len(j);
        chk(tx_abort == 1'b1, "R6", "abort on first collision", tx_abort, 1);
        chk(coll_count == 5'd1, "R6", "coll_count with retry off", coll_count, 1);
        tx_req = 1'b0;
        collision = 1'b0;
        retry_dis = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_full_duplex;
        int n;
        bit bad = 1'b0;
        full_duplex = 1'b1;
        carrier_sense = 1'b1;
        collision = 1'b1;
        @(negedge clk);
        tx_req = 1'b1;
        wait_grant(n);
        chk(n == 1 + IFG, "R9", "grant ignores carrier", n, 1 + IFG);
        repeat (10) begin
            @(negedge clk);
            if (jam || !tx_en) bad = 1'b1;
        end
        chk(!bad, "R9", "collision ignored in full duplex", bad, 0);
        finish_frame(0, "R9");
        carrier_sense = 1'b0;
        collision = 1'b0;
    endtask

    task automatic t_pause;
        full_duplex = 1'b1;
        carrier_sense = 1'b1;
        rx_buf_low = 1'b1;
        @(negedge clk);
        chk(pause_req == 1'b1 && pause_slots == PSL, "R10", "pause on low", pause_slots, PSL);
        chk(jam == 1'b0, "R9", "no back-pressure in full duplex", jam, 0);
        @(negedge clk);
        chk(pause_req == 1'b0, "R10", "pause one cycle", pause_req, 0);
        rx_buf_low = 1'b0;
        @(negedge clk);
        chk(pause_req == 1'b1 && pause_slots == 16'h0, "R10", "resume request", pause_slots, 0);
        carrier_sense = 1'b0;
        full_duplex = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_backpressure;
        carrier_sense = 1'b1;
        rx_buf_low = 1'b1;
        @(negedge clk);
        chk(jam && tx_en, "R8", "back-pressure jam", jam, 1);
        chk(pause_req == 1'b0, "R10", "no pause in half duplex", pause_req, 0);
        carrier_sense = 1'b0;
        @(negedge clk);
        chk(jam == 1'b0, "R8", "no jam without carrier", jam, 0);
        carrier_sense = 1'b1;
        rx_buf_low = 1'b0;
        @(negedge clk);
        chk(jam == 1'b0 && pause_req == 1'b0, "R8", "no jam with buffers free", jam, 0);
        carrier_sense = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_speed;
        int n;
        speed_100 = 1'b0;
        @(negedge clk);
        tx_req = 1'b1;
        wait_grant(n);
        chk(n == 1 + IFG * SDIV, "R11", "slow bit time gap", n, 1 + IFG * SDIV);
        finish_frame(0, "R11");
        speed_100 = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_defer();
        t_collision();
        t_abort();
        t_retry_dis();
        t_full_duplex();
        t_pause();
        t_backpressure();
        t_speed();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule